// File: doc/BRIEF.md
# Parallel Converter Host Sequencer

This block is the host-side controller for a 12-bit converter that has a parallel bus. It sequences the converter's chip select, write strobe, read strobe and two address lines from a single system clock. It also produces the converter's sampling clock by dividing the system clock.

When a start request arrives with a 2-bit channel number, the sequencer launches a conversion and waits for the converter's ready line to rise. It then runs a read cycle and presents the captured word with a one-cycle valid strobe. The setup time, the width of the write strobe and the width of the read strobe are each programmable as a number of system clock cycles.

The low address line also serves as a power command when the read strobe rises. If it is high at that moment, the converter powers down. Each read is therefore tagged with an intent. A plain read holds that line low. A read that ends in power-down holds it high. A later wake request runs a bare read cycle with the line low to bring the converter back. A timeout, counted in sampling-clock edges, aborts a conversion whose ready line never returns and raises an error flag.

Top module: `adc_host_seq`

## Requirements
- R1: In reset and right after it, select, write and read strobes are high (inactive), `data_vld_o`, `seq_busy_o`, `timeout_err_o` and `powered_down_o` are 0.
- R2: An accepted start drives select low and `adc_addr_o` to the channel for `setup_len_i`+1 cycles, then holds the write strobe low for `wr_len_i`+1 cycles with select low and the address unchanged, then releases both.
- R3: `adc_clk_o` is high for `HALF_CYC` system cycles and low for `HALF_CYC` cycles. Elaboration stops if `HALF_CYC*CLK_PERIOD_NS` is below 150.
- R4: After the ready line (high = idle) rises, select and read strobe go low together for `rd_len_i`+1 cycles. The word on `adc_data_i` in the last of those cycles appears on `data_o`, bit 11 being the MSB in straight binary, with `data_vld_o` high for exactly one cycle.
- R5: For a start with `pd_after_i`=0, `adc_addr_o[0]` is 0 and `adc_addr_o[1]` equals channel bit 1 during the read-low cycles and the cycle after the read strobe rises.
- R6: For a start with `pd_after_i`=1, `adc_addr_o[0]` is 1 over those same cycles. Select stays low for one cycle after the read strobe rises, after which `powered_down_o` is 1.
- R7: While `powered_down_o` is 1, start requests are ignored. A wake request runs select low for `setup_len_i`+1 cycles, then read low for `rd_len_i`+1 cycles with `adc_addr_o[0]`=0, without any write strobe or `data_vld_o`, and then clears `powered_down_o`.
- R8: `seq_busy_o` is 1 from the cycle after an accepted request until the sequence ends. Requests arriving while it is 1 are ignored, and each start produces exactly one write strobe.
- R9: If the ready line has not risen within `timeout_i` rising edges of `adc_clk_o` after the write strobe ends, the sequence aborts with no read strobe and `timeout_err_o` goes to 1. The flag clears when the next start is accepted.
- R10: A start and a wake in the same cycle select the wake when powered down and the start when awake. A wake while awake is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request |
| chan_i | input | 2 | Channel for the request |
| pd_after_i | input | 1 | Power down after this conversion's read |
| wake_i | input | 1 | Wake request |
| setup_len_i | input | CNT_W | Select-to-strobe setup, cycles minus one |
| wr_len_i | input | CNT_W | Write strobe width, cycles minus one |
| rd_len_i | input | CNT_W | Read strobe width, cycles minus one |
| timeout_i | input | TO_W | Ready timeout in sampling-clock edges |
| adc_ready_i | input | 1 | Converter ready, low during conversion |
| adc_data_i | input | DATA_W | Converter output bus |
| adc_clk_o | output | 1 | Divided sampling clock |
| adc_sel_n_o | output | 1 | Chip select, active low |
| adc_start_n_o | output | 1 | Write strobe, active low |
| adc_read_n_o | output | 1 | Read strobe, active low |
| adc_addr_o | output | 2 | Address lines, bit 0 doubles as power command |
| data_o | output | DATA_W | Last captured word |
| data_vld_o | output | 1 | One-cycle valid for data_o |
| seq_busy_o | output | 1 | Sequence in progress |
| timeout_err_o | output | 1 | Ready timeout flag |
| powered_down_o | output | 1 | Converter commanded into power-down |

## Verification
A start and a wake can arrive in the same cycle, and which one is accepted depends on the power state. The bench drives both in one cycle while the converter is powered down and expects a bare read with the low address line at 0, no write strobe, and the power flag cleared. It then drives both again while the converter is awake and expects a normal conversion with one write strobe and one valid word. A lone wake while awake is checked to leave the strobes and the busy flag untouched.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_WR_LO = 3'd2,
      ST_CONV  = 3'd3,
      ST_RD_LO = 3'd4,
      ST_RD_HI = 3'd5
   } seq_state_e;

endpackage

// File: rtl/adc_clk_gen.sv
module adc_clk_gen #(
   parameter int HALF_CYC      = 16,
   parameter int CLK_PERIOD_NS = 10
) (
   input  logic clk,
   input  logic rst_n,
   output logic cclk_o,
   output logic rise_o
);

   localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC must be at least 1");
      end
      if (HALF_CYC * CLK_PERIOD_NS < 150) begin : g_bad_phase
         $error("sampling clock phase shorter than 150 ns");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          cclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         cclk_q <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q  <= '0;
         cclk_q <= ~cclk_q;
      end else begin
         cnt_q  <= cnt_q + CW'(1);
      end
   end

   assign cclk_o = cclk_q;
   assign rise_o = (cnt_q == LAST) && !cclk_q;

   // R3
   clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != LAST) |=> $stable(cclk_q));

endmodule

// File: rtl/adc_ready_sync.sv
module adc_ready_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ready_i,
   output logic rise_o
);

   logic synced;
   logic prev_q;

   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_direct
         assign synced = ready_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '1;
            end else begin
               chain_q[0] <= ready_i;
               for (int i = 1; i < STAGES; i++) begin
                  chain_q[i] <= chain_q[i-1];
               end
            end
         end
         assign synced = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= synced;
   end

   assign rise_o = synced && !prev_q;

   // R4
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
   parameter int TO_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run_i,
   input  logic            tick_i,
   input  logic [TO_W-1:0] limit_i,
   output logic            expire_o
);

   generate
      if (TO_W < 1) begin : g_bad_width
         $error("TO_W must be at least 1");
      end
   endgenerate

   logic [TO_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (tick_i && (cnt_q != '1)) begin
         cnt_q <= cnt_q + TO_W'(1);
      end
   end

   assign expire_o = run_i && (cnt_q >= limit_i);

   // R9
   timer_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && $past(run_i)) |-> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_host_pkg::*;
#(
   parameter int CNT_W  = 4,
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        chan_i,
   input  logic              pd_after_i,
   input  logic              wake_i,
   input  logic [CNT_W-1:0]  setup_len_i,
   input  logic [CNT_W-1:0]  wr_len_i,
   input  logic [CNT_W-1:0]  rd_len_i,
   input  logic              ready_rise_i,
   input  logic              expire_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              sel_n_o,
   output logic              start_n_o,
   output logic              read_n_o,
   output logic [1:0]        addr_o,
   output logic              conv_wait_o,
   output logic [DATA_W-1:0] data_o,
   output logic              data_vld_o,
   output logic              seq_busy_o,
   output logic              err_o,
   output logic              pd_o
);

   seq_state_e        state;
   logic [CNT_W-1:0]  cnt_q;
   logic [1:0]        chan_q;
   logic              pd_req_q;
   logic              wake_q;
   logic [DATA_W-1:0] data_q;
   logic              vld_q;
   logic              err_q;
   logic              pd_q;
   logic              cnt_done;

   assign cnt_done = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt_q    <= '0;
         chan_q   <= '0;
         pd_req_q <= 1'b0;
         wake_q   <= 1'b0;
         data_q   <= '0;
         vld_q    <= 1'b0;
         err_q    <= 1'b0;
         pd_q     <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (pd_q) begin
                  if (wake_i) begin
                     wake_q   <= 1'b1;
                     pd_req_q <= 1'b0;
                     cnt_q    <= setup_len_i;
                     state    <= ST_SETUP;
                  end
               end else if (start_i) begin
                  chan_q   <= chan_i;
                  pd_req_q <= pd_after_i;
                  wake_q   <= 1'b0;
                  err_q    <= 1'b0;
                  cnt_q    <= setup_len_i;
                  state    <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (cnt_done) begin
                  if (wake_q) begin
                     cnt_q <= rd_len_i;
                     state <= ST_RD_LO;
                  end else begin
                     cnt_q <= wr_len_i;
                     state <= ST_WR_LO;
                  end
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            ST_WR_LO: begin
               if (cnt_done) state <= ST_CONV;
               else          cnt_q <= cnt_q - CNT_W'(1);
            end
            ST_CONV: begin
               if (ready_rise_i) begin
                  cnt_q <= rd_len_i;
                  state <= ST_RD_LO;
               end else if (expire_i) begin
                  err_q <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            ST_RD_LO: begin
               if (cnt_done) begin
                  if (!wake_q) begin
                     data_q <= data_i;
                     vld_q  <= 1'b1;
                  end
                  state <= ST_RD_HI;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            ST_RD_HI: begin
               if (wake_q)        pd_q <= 1'b0;
               else if (pd_req_q) pd_q <= 1'b1;
               wake_q <= 1'b0;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      sel_n_o   = !(state inside {ST_SETUP, ST_WR_LO, ST_RD_LO, ST_RD_HI});
      start_n_o = (state != ST_WR_LO);
      read_n_o  = (state != ST_RD_LO);
      if (state inside {ST_RD_LO, ST_RD_HI}) addr_o = {chan_q[1], pd_req_q};
      else                                    addr_o = chan_q;
   end

   assign conv_wait_o = (state == ST_CONV);
   assign seq_busy_o  = (state != ST_IDLE);
   assign data_o      = data_q;
   assign data_vld_o  = vld_q;
   assign err_o       = err_q;
   assign pd_o        = pd_q;

   // R2
   wr_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_n_o && $past(!start_n_o)) |-> $stable(addr_o));

   // R4
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_vld_o |=> !data_vld_o);

   // R4
   read_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(read_n_o) && !wake_q) |-> $past(ready_rise_i));

   // R9
   err_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> $past(state == ST_CONV));

   // R7
   wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pd_o) |-> $past(wake_q));

endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq #(
   parameter int HALF_CYC      = 16,
   parameter int CLK_PERIOD_NS = 10,
   parameter int SYNC_STAGES   = 2,
   parameter int CNT_W         = 4,
   parameter int TO_W          = 8,
   parameter int DATA_W        = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        chan_i,
   input  logic              pd_after_i,
   input  logic              wake_i,
   input  logic [CNT_W-1:0]  setup_len_i,
   input  logic [CNT_W-1:0]  wr_len_i,
   input  logic [CNT_W-1:0]  rd_len_i,
   input  logic [TO_W-1:0]   timeout_i,
   input  logic              adc_ready_i,
   input  logic [DATA_W-1:0] adc_data_i,
   output logic              adc_clk_o,
   output logic              adc_sel_n_o,
   output logic              adc_start_n_o,
   output logic              adc_read_n_o,
   output logic [1:0]        adc_addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              data_vld_o,
   output logic              seq_busy_o,
   output logic              timeout_err_o,
   output logic              powered_down_o
);

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
   endgenerate

   logic cclk_rise;
   logic ready_rise;
   logic conv_wait;
   logic expire;

   adc_clk_gen #(
      .HALF_CYC      (HALF_CYC),
      .CLK_PERIOD_NS (CLK_PERIOD_NS)
   ) u_clk (
      .clk    (clk),
      .rst_n  (rst_n),
      .cclk_o (adc_clk_o),
      .rise_o (cclk_rise)
   );

   adc_ready_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .ready_i (adc_ready_i),
      .rise_o  (ready_rise)
   );

   adc_conv_timer #(
      .TO_W (TO_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (conv_wait),
      .tick_i   (cclk_rise),
      .limit_i  (timeout_i),
      .expire_o (expire)
   );

   adc_seq_ctrl #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .chan_i       (chan_i),
      .pd_after_i   (pd_after_i),
      .wake_i       (wake_i),
      .setup_len_i  (setup_len_i),
      .wr_len_i     (wr_len_i),
      .rd_len_i     (rd_len_i),
      .ready_rise_i (ready_rise),
      .expire_i     (expire),
      .data_i       (adc_data_i),
      .sel_n_o      (adc_sel_n_o),
      .start_n_o    (adc_start_n_o),
      .read_n_o     (adc_read_n_o),
      .addr_o       (adc_addr_o),
      .conv_wait_o  (conv_wait),
      .data_o       (data_o),
      .data_vld_o   (data_vld_o),
      .seq_busy_o   (seq_busy_o),
      .err_o        (timeout_err_o),
      .pd_o         (powered_down_o)
   );

endmodule

// File: tb/tb_adc_host_seq.sv
module tb_adc_host_seq;

   localparam int CLK_PER = 10;
   localparam int HALF    = 2;
   localparam int CW      = 4;
   localparam int TW      = 6;
   localparam int DW      = 12;
   localparam int TO_LIM  = 20;
   localparam int CONV_CY = 14;

   logic clk = 1'b0;
   always #(CLK_PER/2) clk = ~clk;

   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    chan = '0;
   logic          pd_after = 1'b0;
   logic          wake = 1'b0;
   logic [CW-1:0] setup_len = '0;
   logic [CW-1:0] wr_len = '0;
   logic [CW-1:0] rd_len = '0;
   logic          adc_ready = 1'b1;
   logic [DW-1:0] adc_data = '0;
   logic          cclk, sel_n, start_n, read_n, vld, busy, err, pd;
   logic [1:0]    addr;
   logic [DW-1:0] data;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  hang  = 1'b0;
   logic [DW-1:0] word = '0;

   adc_host_seq #(
      .HALF_CYC(HALF), .CLK_PERIOD_NS(100), .SYNC_STAGES(2),
      .CNT_W(CW), .TO_W(TW), .DATA_W(DW)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .chan_i(chan),
      .pd_after_i(pd_after), .wake_i(wake), .setup_len_i(setup_len),
      .wr_len_i(wr_len), .rd_len_i(rd_len), .timeout_i(TW'(TO_LIM)),
      .adc_ready_i(adc_ready), .adc_data_i(adc_data), .adc_clk_o(cclk),
      .adc_sel_n_o(sel_n), .adc_start_n_o(start_n), .adc_read_n_o(read_n),
      .adc_addr_o(addr), .data_o(data), .data_vld_o(vld), .seq_busy_o(busy),
      .timeout_err_o(err), .powered_down_o(pd)
   );

   // converter model: ready drops at the write strobe fall, returns later
   always begin
      @(negedge start_n);
      adc_ready = 1'b0;
      adc_data  = ~word;
      if (!hang) begin
         repeat (CONV_CY) @(posedge clk);
         #1;
         adc_data  = word;
         adc_ready = 1'b1;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic do_conv(input logic [1:0] ch, input bit pdr, input int su,
                          input int wl, input int rl, input bit poke,
                          input bit with_wake, input logic [DW-1:0] w);
      int  n_setup = 0, n_wr = 0, n_rd = 0, n_hi = 0, n_v = 0;
      int  bad_w = 0, bad_r = 0, falls = 0, guard = 0, idle_bad = 0;
      bit  poked = 1'b0;
      logic prev_wr = 1'b1;
      logic [DW-1:0] got = '0;
      word      = w;
      setup_len = CW'(su);
      wr_len    = CW'(wl);
      rd_len    = CW'(rl);
      @(negedge clk);
      start = 1'b1; chan = ch; pd_after = pdr; wake = with_wake;
      @(negedge clk);
      start = 1'b0; pd_after = 1'b0; wake = 1'b0;
      chk("R8 busy after accepted start", busy, 1);
      chk("R9 error cleared on accepted start", err, 0);
      while (busy && guard < 2000) begin
         if (!sel_n && start_n && read_n && n_wr == 0) n_setup++;
         if (prev_wr && !start_n) falls++;
         if (!start_n) begin
            n_wr++;
            if (addr != ch || sel_n) bad_w++;
         end
         if (!read_n) begin
            n_rd++;
            if (sel_n || addr[0] != pdr || addr[1] != ch[1]) bad_r++;
         end else if (n_rd > 0 && !sel_n) begin
            n_hi++;
            if (addr[0] != pdr) bad_r++;
         end
         if (vld) begin n_v++; got = data; end
         if (poke && !poked && n_wr > 0 && start_n && sel_n) begin
            start = 1'b1; chan = ~ch; poked = 1'b1;
         end else begin
            start = 1'b0;
         end
         prev_wr = start_n;
         guard++;
         @(negedge clk);
      end
      start = 1'b0;
      chk("R2 setup cycles before write strobe", n_setup, su + 1);
      chk("R2 write strobe width", n_wr, wl + 1);
      chk("R2 address and select during write strobe", bad_w, 0);
      chk("R8 one write strobe per start", falls, 1);
      chk("R4 read strobe width", n_rd, rl + 1);
      if (pdr) chk("R6 power command on low address line", bad_r, 0);
      else     chk("R5 low address line zero on plain read", bad_r, 0);
      chk("R6 select held one cycle after read rises", n_hi, 1);
      chk("R4 single valid pulse", n_v, 1);
      chk("R4 captured word", int'(got), int'(w));
      chk("R6 power state after read", pd, pdr);
      for (int i = 0; i < 3; i++) begin
         if (busy || !sel_n) idle_bad++;
         @(negedge clk);
      end
      chk("R8 idle after sequence", idle_bad, 0);
   endtask

   task automatic do_wake(input bit also_start, input int su, input int rl);
      int n_setup = 0, n_rd = 0, n_wr = 0, n_v = 0, bad = 0, guard = 0;
      setup_len = CW'(su);
      rd_len    = CW'(rl);
      @(negedge clk);
      wake = 1'b1; start = also_start; chan = 2'd1;
      @(negedge clk);
      wake = 1'b0; start = 1'b0;
      chk("R7 busy after wake", busy, 1);
      while (busy && guard < 2000) begin
         if (!sel_n && read_n && start_n && n_rd == 0) n_setup++;
         if (!start_n) n_wr++;
         if (!read_n) begin
            n_rd++;
            if (addr[0] != 1'b0 || sel_n) bad++;
         end
         if (vld) n_v++;
         guard++;
         @(negedge clk);
      end
      chk("R7 wake setup cycles", n_setup, su + 1);
      chk("R7 wake read width", n_rd, rl + 1);
      chk("R7 wake low address line zero", bad, 0);
      chk("R7 no valid on wake", n_v, 0);
      if (also_start) chk("R10 wake wins over start when powered down", n_wr, 0);
      else            chk("R7 no write strobe on wake", n_wr, 0);
      chk("R7 power state cleared", pd, 0);
   endtask

   task automatic quiet_window(input string tag, input bit st, input bit wk);
      int act = 0;
      @(negedge clk);
      start = st; wake = wk;
      @(negedge clk);
      start = 1'b0; wake = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (busy || !sel_n || !start_n || !read_n) act++;
         @(negedge clk);
      end
      chk(tag, act, 0);
   endtask

   initial begin
      #(CLK_PER * 100000);
      n_bad++;
      $display("FAIL R8 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 select idle in reset", sel_n, 1);
      chk("R1 write idle in reset", start_n, 1);
      chk("R1 read idle in reset", read_n, 1);
      chk("R1 flags clear in reset", {vld, busy, err, pd}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {sel_n, start_n, read_n, vld, busy, err, pd}, 7'b1110000);

      // R3 sampling clock phases
      begin
         logic p;
         int r;
         p = cclk;
         while (cclk == p) @(negedge clk);
         for (int k = 0; k < 2; k++) begin
            r = 0; p = cclk;
            while (cclk == p) begin r++; @(negedge clk); end
            chk("R3 sampling clock phase length", r, HALF);
         end
      end

      // sweep: channel x setup x write width x read width
      for (int ch = 0; ch < 4; ch++)
         for (int su = 0; su < 3; su += 2)
            for (int wl = 0; wl < 4; wl += 3)
               for (int rl = 0; rl < 3; rl += 2)
                  do_conv(2'(ch), 1'b0, su, wl, rl, (su == 2), 1'b0,
                          DW'(ch * 1111 + su * 77 + wl * 301 + rl * 13));
      do_conv(2'd3, 1'b0, 1, 1, 1, 1'b0, 1'b0, 12'h000);
      do_conv(2'd0, 1'b0, 1, 1, 1, 1'b0, 1'b0, 12'hFFF);
      do_conv(2'd2, 1'b0, 0, 2, 3, 1'b0, 1'b0, 12'h800);

      // power-down, start ignored, wake + start together
      do_conv(2'd2, 1'b1, 1, 1, 2, 1'b0, 1'b0, 12'h5A5);
      quiet_window("R7 start ignored while powered down", 1'b1, 1'b0);
      chk("R7 still powered down", pd, 1);
      do_wake(1'b1, 2, 1);
      quiet_window("R10 wake ignored while awake", 1'b0, 1'b1);
      do_conv(2'd1, 1'b0, 0, 0, 0, 1'b0, 1'b1, 12'h3C3);   // R10 start wins when awake
      do_conv(2'd3, 1'b1, 0, 1, 0, 1'b0, 1'b0, 12'hA5A);
      do_wake(1'b0, 0, 3);

      // R9 timeout
      begin
         int n_conv = 0, n_rd = 0, guard = 0;
         hang = 1'b1;
         @(negedge clk);
         start = 1'b1; chan = 2'd0;
         @(negedge clk);
         start = 1'b0;
         while (busy && guard < 2000) begin
            if (sel_n && start_n && read_n) n_conv++;
            if (!read_n) n_rd++;
            guard++;
            @(negedge clk);
         end
         chk("R9 error flag after timeout", err, 1);
         chk("R9 no read after timeout", n_rd, 0);
         chk("R9 wait length in range",
             int'(n_conv >= 4*TO_LIM - 2 && n_conv <= 4*TO_LIM + 2), 1);
         chk("R9 strobes idle after abort", {sel_n, start_n, read_n}, 3'b111);
         hang = 1'b0;
         adc_ready = 1'b1;
         repeat (6) @(negedge clk);
         chk("R9 error held while idle", err, 1);
      end
      do_conv(2'd1, 1'b0, 1, 1, 1, 1'b0, 1'b0, 12'h123);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule